// File: doc/BRIEF.md
# Bidirectional GPIO Port with Toggle-on-Write

This block is a parameterized general-purpose I/O port, eight bits wide by default. Three registers control it: a direction register, an output data register and a pin register. The direction register chooses, bit by bit, between driving a pad and listening to it. The output data register has two jobs. On an output bit it sets the driven level. On an input bit it turns on the pad's pull-up.

The pin register reads back the pad level. That level first passes through a two-flop synchronizer, and the read returns it whatever the direction setting is. A write to the pin register's offset does not store anything. Instead, each 1 in the written word flips the matching output data bit, and each 0 leaves its bit alone.

Software reaches the registers through a small bus. It has a write strobe, a two-bit offset and a data word. A write takes effect on the clock edge where the strobe is high. Read data follows the offset combinationally. Each pad gets three signals from the block: an output value, an output enable and a pull-up enable.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, and on the first cycle after it, the direction and output data registers read 0, pad_oe is all 0, pad_pu is all 0 and a read of offset 0 returns 0.
- R2: A write to offset 1 loads the direction register from bus_wdata. A direction bit of 1 means output and 0 means input. A read of offset 1 returns the stored value.
- R3: A write to offset 2 loads the output data register from bus_wdata. A read of offset 2 returns the stored value.
- R4: A write to offset 0 inverts each output data bit whose bus_wdata bit is 1, whatever the direction. Bits written 0 keep their value.
- R5: pad_oe equals the direction register. pad_out equals the output data bit where the direction bit is 1, and is 0 where it is 0.
- R6: pad_pu is 1 exactly on bits with direction 0 and data 1. pad_pu and pad_oe are never both 1 on the same bit.
- R7: A read of offset 0 returns the value pad_in had two clock edges earlier, for input and output bits alike. A level the port drives itself therefore comes back through the synchronizer.
- R8: A write to offset 3 changes no register. A read of offset 3 returns 0.
- R9: A write changes its register and the pad signals on the same clock edge that samples the strobe. bus_rdata changes in the same cycle that bus_addr changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset: 0 pin, 1 direction, 2 output data, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| pad_in | input | WIDTH | Pad input levels, asynchronous |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |

## Verification
Two functions can fall in the same cycle: a toggle write on offset 0 and a read of the pin register at that same offset. This happens when the toggled bits are outputs looped back onto pad_in. The read must return the older synchronized level, not the newly driven one. The new level must then show up on the pin read exactly two edges later.

The bench loops pad_out back onto pad_in wherever pad_oe is set and issues back-to-back toggles while reading offset 0. A behavioural model predicts the read data and the pad signals. The bench compares them every cycle, including the cycles around direction changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= sync_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];

  // checker: cycles since reset, saturating
  logic [CW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != CW'(STAGES)) cyc <= cyc + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      p_sync_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc == CW'(STAGES)) |-> (sync_out == $past(sync_in, 2)));
    end
  endgenerate

  p_sync_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (sync_out == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  data_q
);
  logic wr_dir, wr_data, wr_tgl;

  always_comb begin
    wr_dir  = wr && (addr == OFS_DIR);
    wr_data = wr && (addr == OFS_DATA);
    wr_tgl  = wr && (addr == OFS_PIN);
  end

  always_ff @(posedge clk) begin
    if (rst) dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else if (wr_data) data_q <= wdata;
    else if (wr_tgl) data_q <= data_q ^ wdata;
  end

  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_PIN) |=> (data_q == ($past(data_q) ^ $past(wdata))));
  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_DIR) |=> (dir_q == $past(wdata)));
  p_data_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_DATA) |=> (data_q == $past(wdata)));
  p_unused_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd3) |=> ($stable(dir_q) && $stable(data_q)));
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && data_q == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pad_oe[b]  = dir_q[b];
      assign pad_out[b] = dir_q[b] & data_q[b];
      assign pad_pu[b]  = ~dir_q[b] & data_q[b];
    end
  endgenerate

  always_comb begin
    p_pu_excl_oe_r6: assert ((pad_oe & pad_pu) == '0);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  logic [WIDTH-1:0] dir_q, data_q, pin_q;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .data_q(data_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sync_in(pad_in), .sync_out(pin_q)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .dir_q(dir_q), .data_q(data_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_PIN:  bus_rdata = pin_q;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_DATA: bus_rdata = data_q;
      default:  bus_rdata = '0;
    endcase
  end

  p_oe_follows_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata)));
  p_pads_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0));
  p_data_write_pads_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DATA) |=>
      ((pad_out | pad_pu) == $past(bus_wdata)));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_pu, pad_in;
  logic [W-1:0] ext = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  logic [W-1:0] m_dir = '0, m_data = '0, m_s1 = '0, m_s2 = '0;

  always #4 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port #(.WIDTH(W)) u_gpio_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_rdata(input logic [1:0] a);
    case (a)
      2'd0: return m_s2;
      2'd1: return m_dir;
      2'd2: return m_data;
      default: return '0;
    endcase
  endfunction

  // drive inputs at negedge, compare, then advance model at posedge
  task automatic step(input logic wr, input logic [1:0] a,
                      input logic [W-1:0] wd, input logic [W-1:0] e,
                      input string tag);
    logic [W-1:0] mpad;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; ext = e;
    #1;
    chk(tag, "rdata", bus_rdata, m_rdata(a));
    chk("R5", "pad_oe", pad_oe, m_dir);
    chk("R5", "pad_out", pad_out, m_dir & m_data);
    chk("R6", "pad_pu", pad_pu, ~m_dir & m_data);
    mpad = (m_dir & m_data) | (~m_dir & e);
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = mpad;
    if (wr && a == 2'd1) m_dir = wd;
    if (wr && a == 2'd2) m_data = wd;
    if (wr && a == 2'd0) m_data = m_data ^ wd;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=200000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    ext = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "pad_oe", pad_oe, '0);
    chk("R1", "pad_pu", pad_pu, '0);
    chk("R1", "pin read", bus_rdata, '0);
    step(0, 2'd1, 8'h00, 8'hA5, "R1");
    step(0, 2'd2, 8'h00, 8'hA5, "R1");
    // R7 inputs through synchronizer
    step(0, 2'd0, 8'h00, 8'h3C, "R7");
    step(0, 2'd0, 8'h00, 8'hC3, "R7");
    step(0, 2'd0, 8'h00, 8'hFF, "R7");
    step(0, 2'd0, 8'h00, 8'h00, "R7");
    // R3 data while input: pull-ups
    step(1, 2'd2, 8'h5A, 8'h00, "R9");
    step(0, 2'd2, 8'h00, 8'h00, "R3");
    // R4 toggle with all inputs
    step(1, 2'd0, 8'h0F, 8'h00, "R4");
    step(0, 2'd2, 8'h00, 8'h00, "R4");
    // R2 direction
    step(1, 2'd1, 8'hF0, 8'h0F, "R9");
    step(0, 2'd1, 8'h00, 8'h0F, "R2");
    // R4 with R7 same cycle: toggles on outputs looped back, read pin
    step(1, 2'd0, 8'hFF, 8'h0F, "R4");
    step(1, 2'd0, 8'h81, 8'h0F, "R4");
    step(1, 2'd0, 8'h18, 8'h0F, "R7");
    step(0, 2'd0, 8'h00, 8'h00, "R7");
    step(0, 2'd0, 8'h00, 8'h00, "R7");
    step(0, 2'd2, 8'h00, 8'h00, "R4");
    // R8 unused offset
    step(1, 2'd3, 8'hFF, 8'h00, "R8");
    step(0, 2'd3, 8'h00, 8'h00, "R8");
    step(0, 2'd1, 8'h00, 8'h00, "R8");
    step(0, 2'd2, 8'h00, 8'h00, "R8");
    // R9 back-to-back writes and address sweeps
    step(1, 2'd1, 8'hFF, 8'h00, "R9");
    step(1, 2'd2, 8'hAA, 8'h00, "R9");
    step(1, 2'd0, 8'h55, 8'h00, "R9");
    for (int i = 0; i < 8; i++) step(0, 2'(i % 4), 8'h00, 8'h00, "R9");
    step(1, 2'd1, 8'h0F, 8'h66, "R2");
    for (int i = 0; i < 4; i++) step(0, 2'd0, 8'h00, 8'(8'h11 * i), "R7");
    step(1, 2'd0, 8'hFF, 8'h00, "R4");
    step(0, 2'd2, 8'h00, 8'h00, "R4");
    // reset again mid-run
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_dir = '0; m_data = '0; m_s1 = '0; m_s2 = '0;
    #1;
    chk("R1", "pad_oe after reset", pad_oe, '0);
    chk("R1", "pad_pu after reset", pad_pu, '0);
    step(0, 2'd2, 8'h00, 8'h00, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule